// File: doc/BRIEF.md
# Accumulator ALU Operation Executor

This block carries out one single-byte accumulator instruction of an 8-bit processor. A fetch stage supplies the opcode, the six general-purpose register values, an immediate byte and a byte read from the address held in the HL pair. The block runs one of eight operation groups against the accumulator: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. It keeps the accumulator and the four flags (zero, subtract, half-carry, carry) in its own registers. These registers change only on the clock edge where the execute strobe is high and the instruction can complete.

The decode is combinational. It reports how far the program counter must advance and, for memory-operand forms, raises a read request toward the memory system. An instruction that needs the memory byte stays pending until its data is marked valid. The fetch stage therefore keeps the strobe high until that happens. An opcode outside the supported set reports a zero advance and leaves the state as it was.

Top module: `accalu_exec`

## Requirements
- R1: While reset is asserted, and until it has been released for two clock edges, the accumulator reads 0x00 and all four flags read 0.
- R2: In register forms (opcode bits 7:6 = 10), opcode bits 2:0 select the operand in this order: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=memory byte at HL, 7=accumulator. The immediate forms are the opcodes with bits 7:6 = 11 and bits 2:0 = 110, and they take the immediate byte. In both forms opcode bits 5:3 select the group: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 XOR, 6 OR, 7 compare.
- R3: The PC advance output is 1 for register and memory forms and 2 for immediate forms. It is 0 for any other opcode, and executing such an opcode changes neither the accumulator nor the flags.
- R4: AND writes A&operand and sets zero from the result, subtract=0, half-carry=1 and carry=0.
- R5: XOR and OR write the result and set zero from it, with subtract, half-carry and carry all 0.
- R6: Add computes A+operand, and add with carry also adds the stored carry flag. Half-carry is the carry out of the low four bits including the carry-in, carry is the carry out of bit 7, subtract is 0 and zero comes from the 8-bit result.
- R7: Subtract computes A-operand, and subtract with borrow also subtracts the stored carry flag. Half-carry is set when the low nibble of A is less than the low nibble of the operand plus the carry-in, carry is set when A is less than the operand plus the carry-in, subtract is 1 and zero comes from the 8-bit result.
- R8: Compare sets all four flags exactly as a subtract would and leaves the accumulator unchanged.
- R9: The read request is high exactly when the strobe is high and the opcode is a memory-operand register form. Such an instruction commits only on an edge where the valid input is also high, and until then the state holds.
- R10: With the strobe low, the accumulator and flags hold whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe for the presented opcode |
| opcode_i | input | 8 | Instruction byte |
| reg_b_i | input | 8 | Register B value |
| reg_c_i | input | 8 | Register C value |
| reg_d_i | input | 8 | Register D value |
| reg_e_i | input | 8 | Register E value |
| reg_h_i | input | 8 | Register H value |
| reg_l_i | input | 8 | Register L value |
| hl_data_i | input | 8 | Byte read from the address in HL |
| hl_valid_i | input | 1 | hl_data_i holds the requested byte |
| imm_i | input | 8 | Immediate byte following the opcode |
| acc_o | output | 8 | Accumulator |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Subtract flag |
| flag_h_o | output | 1 | Half-carry flag |
| flag_c_o | output | 1 | Carry flag |
| pc_step_o | output | 2 | Program counter advance for the opcode |
| hl_rd_req_o | output | 1 | Request to read memory at HL |

## Verification
The PC advance and the read request are combinational: they are due in the same cycle the opcode and strobe are presented. The bench drives on the falling edge and checks them a short delay later, before the next rising edge. The accumulator and flags are due right after the first rising edge at which the strobe is high and any memory byte is valid. The bench therefore lowers the strobe on the falling edge after that and checks the registered values there, one edge after the stimulus. In the memory-wait case it checks at each falling edge that nothing has changed yet.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

  typedef enum logic [2:0] {
    GRP_ADD = 3'd0,
    GRP_ADC = 3'd1,
    GRP_SUB = 3'd2,
    GRP_SBC = 3'd3,
    GRP_AND = 3'd4,
    GRP_XOR = 3'd5,
    GRP_OR  = 3'd6,
    GRP_CMP = 3'd7
  } alu_grp_e;

  typedef enum logic [2:0] {
    SRC_B   = 3'd0,
    SRC_C   = 3'd1,
    SRC_D   = 3'd2,
    SRC_E   = 3'd3,
    SRC_H   = 3'd4,
    SRC_L   = 3'd5,
    SRC_MEM = 3'd6,
    SRC_A   = 3'd7
  } src_sel_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

endpackage

// File: rtl/accalu_decode.sv
module accalu_decode
  import accalu_pkg::*;
#(
  parameter int unsigned OPW = 8
) (
  input  logic [OPW-1:0] opcode_i,
  output logic           legal_o,
  output alu_grp_e       grp_o,
  output src_sel_e       src_o,
  output logic           is_imm_o,
  output logic           uses_mem_o,
  output logic [1:0]     pc_step_o
);

  localparam int unsigned TOP_HI = OPW - 1;
  localparam int unsigned TOP_LO = OPW - 2;

  logic reg_form;
  logic imm_form;

  always_comb begin
    reg_form = (opcode_i[TOP_HI:TOP_LO] == 2'b10);
    imm_form = (opcode_i[TOP_HI:TOP_LO] == 2'b11) && (opcode_i[2:0] == 3'b110);
  end

  always_comb begin
    legal_o    = reg_form || imm_form;
    grp_o      = alu_grp_e'(opcode_i[5:3]);
    src_o      = src_sel_e'(opcode_i[2:0]);
    is_imm_o   = imm_form;
    uses_mem_o = reg_form && (src_sel_e'(opcode_i[2:0]) == SRC_MEM);
    if (imm_form) begin
      pc_step_o = 2'd2;
    end else if (reg_form) begin
      pc_step_o = 2'd1;
    end else begin
      pc_step_o = 2'd0;
    end
  end

endmodule

// File: rtl/accalu_opsel.sv
module accalu_opsel
  import accalu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  src_sel_e      src_i,
  input  logic          is_imm_i,
  input  logic [DW-1:0] reg_b_i,
  input  logic [DW-1:0] reg_c_i,
  input  logic [DW-1:0] reg_d_i,
  input  logic [DW-1:0] reg_e_i,
  input  logic [DW-1:0] reg_h_i,
  input  logic [DW-1:0] reg_l_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] hl_data_i,
  input  logic [DW-1:0] imm_i,
  output logic [DW-1:0] opnd_o
);

  localparam int unsigned NSRC = 8;

  logic [NSRC-1:0][DW-1:0] cand;

  always_comb begin
    cand[SRC_B]   = reg_b_i;
    cand[SRC_C]   = reg_c_i;
    cand[SRC_D]   = reg_d_i;
    cand[SRC_E]   = reg_e_i;
    cand[SRC_H]   = reg_h_i;
    cand[SRC_L]   = reg_l_i;
    cand[SRC_MEM] = hl_data_i;
    cand[SRC_A]   = acc_i;
  end

  always_comb begin
    if (is_imm_i) begin
      opnd_o = imm_i;
    end else begin
      opnd_o = cand[src_i];
    end
  end

endmodule

// File: rtl/accalu_core.sv
module accalu_core
  import accalu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  alu_grp_e      grp_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          carry_i,
  output logic [DW-1:0] res_o,
  output logic          wr_acc_o,
  output flags_t        flags_o
);

  localparam int unsigned HW = DW / 2;

  logic          cin;
  logic [HW:0]   add_lo;
  logic [DW:0]   add_full;
  logic [HW:0]   sub_lo;
  logic [DW:0]   sub_full;
  logic [DW-1:0] logic_res;

  always_comb begin
    cin      = ((grp_i == GRP_ADC) || (grp_i == GRP_SBC)) ? carry_i : 1'b0;
    add_lo   = {1'b0, acc_i[HW-1:0]} + {1'b0, opnd_i[HW-1:0]} + {{HW{1'b0}}, cin};
    add_full = {1'b0, acc_i} + {1'b0, opnd_i} + {{DW{1'b0}}, cin};
    sub_lo   = {1'b0, acc_i[HW-1:0]} - {1'b0, opnd_i[HW-1:0]} - {{HW{1'b0}}, cin};
    sub_full = {1'b0, acc_i} - {1'b0, opnd_i} - {{DW{1'b0}}, cin};
  end

  always_comb begin
    unique case (grp_i)
      GRP_AND: logic_res = acc_i & opnd_i;
      GRP_XOR: logic_res = acc_i ^ opnd_i;
      default: logic_res = acc_i | opnd_i;
    endcase
  end

  always_comb begin
    res_o    = acc_i;
    wr_acc_o = 1'b1;
    flags_o  = '0;
    unique case (grp_i)
      GRP_ADD, GRP_ADC: begin
        res_o     = add_full[DW-1:0];
        flags_o.h = add_lo[HW];
        flags_o.c = add_full[DW];
        flags_o.z = (add_full[DW-1:0] == '0);
      end
      GRP_SUB, GRP_SBC, GRP_CMP: begin
        res_o     = sub_full[DW-1:0];
        wr_acc_o  = (grp_i != GRP_CMP);
        flags_o.n = 1'b1;
        flags_o.h = sub_lo[HW];
        flags_o.c = sub_full[DW];
        flags_o.z = (sub_full[DW-1:0] == '0);
      end
      GRP_AND: begin
        res_o     = logic_res;
        flags_o.h = 1'b1;
        flags_o.z = (logic_res == '0);
      end
      default: begin
        res_o     = logic_res;
        flags_o.z = (logic_res == '0);
      end
    endcase
  end

endmodule

// File: rtl/accalu_exec.sv
module accalu_exec
  import accalu_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned SYNC_FF = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_i,
  input  logic [DW-1:0] opcode_i,
  input  logic [DW-1:0] reg_b_i,
  input  logic [DW-1:0] reg_c_i,
  input  logic [DW-1:0] reg_d_i,
  input  logic [DW-1:0] reg_e_i,
  input  logic [DW-1:0] reg_h_i,
  input  logic [DW-1:0] reg_l_i,
  input  logic [DW-1:0] hl_data_i,
  input  logic          hl_valid_i,
  input  logic [DW-1:0] imm_i,
  output logic [DW-1:0] acc_o,
  output logic          flag_z_o,
  output logic          flag_n_o,
  output logic          flag_h_o,
  output logic          flag_c_o,
  output logic [1:0]    pc_step_o,
  output logic          hl_rd_req_o
);

  // reset synchronizer: asserts at once, releases after SYNC_FF edges
  logic [SYNC_FF-1:0] rst_pipe_q;
  logic               rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_FF-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[SYNC_FF-1];

  logic          legal;
  alu_grp_e      grp;
  src_sel_e      src;
  logic          is_imm;
  logic          uses_mem;
  logic [1:0]    pc_step;
  logic [DW-1:0] opnd;
  logic [DW-1:0] res;
  logic          wr_acc;
  flags_t        flg_new;

  logic [DW-1:0] acc_q, acc_d;
  flags_t        flg_q, flg_d;
  logic          commit;

  accalu_decode #(.OPW(DW)) u_decode (
    .opcode_i   (opcode_i),
    .legal_o    (legal),
    .grp_o      (grp),
    .src_o      (src),
    .is_imm_o   (is_imm),
    .uses_mem_o (uses_mem),
    .pc_step_o  (pc_step)
  );

  accalu_opsel #(.DW(DW)) u_opsel (
    .src_i     (src),
    .is_imm_i  (is_imm),
    .reg_b_i   (reg_b_i),
    .reg_c_i   (reg_c_i),
    .reg_d_i   (reg_d_i),
    .reg_e_i   (reg_e_i),
    .reg_h_i   (reg_h_i),
    .reg_l_i   (reg_l_i),
    .acc_i     (acc_q),
    .hl_data_i (hl_data_i),
    .imm_i     (imm_i),
    .opnd_o    (opnd)
  );

  accalu_core #(.DW(DW)) u_core (
    .grp_i    (grp),
    .acc_i    (acc_q),
    .opnd_i   (opnd),
    .carry_i  (flg_q.c),
    .res_o    (res),
    .wr_acc_o (wr_acc),
    .flags_o  (flg_new)
  );

  // next state
  always_comb begin
    commit = exec_i && legal && (!uses_mem || hl_valid_i);
    acc_d  = acc_q;
    flg_d  = flg_q;
    if (commit) begin
      flg_d = flg_new;
      if (wr_acc) begin
        acc_d = res;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      flg_q <= '0;
    end else if (commit) begin
      acc_q <= acc_d;
      flg_q <= flg_d;
    end
  end

  always_comb begin
    acc_o       = acc_q;
    flag_z_o    = flg_q.z;
    flag_n_o    = flg_q.n;
    flag_h_o    = flg_q.h;
    flag_c_o    = flg_q.c;
    pc_step_o   = pc_step;
    hl_rd_req_o = exec_i && uses_mem;
  end

  // R10
  no_exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !exec_i |=> ($stable(acc_o) && $stable({flag_z_o, flag_n_o, flag_h_o, flag_c_o})));

  // R9
  mem_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hl_rd_req_o && !hl_valid_i) |=> ($stable(acc_o) && $stable({flag_z_o, flag_n_o, flag_h_o, flag_c_o})));

  // R9
  mem_req_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hl_rd_req_o |-> (pc_step_o == 2'd1));

  // R3
  unsupported_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_i && (pc_step_o == 2'd0)) |=> ($stable(acc_o) && $stable({flag_z_o, flag_n_o, flag_h_o, flag_c_o})));

  // R4
  and_flags_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (commit && (grp == GRP_AND)) |=> (flag_h_o && !flag_c_o && !flag_n_o && (flag_z_o == (acc_o == '0))));

  // R5
  orx_flags_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (commit && ((grp == GRP_OR) || (grp == GRP_XOR))) |=> (!flag_h_o && !flag_c_o && !flag_n_o && (flag_z_o == (acc_o == '0))));

  // R8
  cmp_keep_acc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (commit && (grp == GRP_CMP)) |=> ($stable(acc_o) && flag_n_o));

  // R6
  add_sub_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (commit && ((grp == GRP_ADD) || (grp == GRP_ADC))) |=> (!flag_n_o && (flag_z_o == (acc_o == '0))));

endmodule

// File: tb/tb_accalu_exec.sv
`timescale 1ns/1ps
module tb_accalu_exec;

  logic       clk;
  logic       rst_n;
  logic       exec_i;
  logic [7:0] opcode_i;
  logic [7:0] reg_b_i, reg_c_i, reg_d_i, reg_e_i, reg_h_i, reg_l_i;
  logic [7:0] hl_data_i;
  logic       hl_valid_i;
  logic [7:0] imm_i;
  logic [7:0] acc_o;
  logic       flag_z_o, flag_n_o, flag_h_o, flag_c_o;
  logic [1:0] pc_step_o;
  logic       hl_rd_req_o;

  int errors = 0;
  int checks = 0;

  // bench-side architectural state
  logic [7:0] m_a;
  logic       m_z, m_n, m_h, m_c;

  accalu_exec dut (
    .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .opcode_i(opcode_i),
    .reg_b_i(reg_b_i), .reg_c_i(reg_c_i), .reg_d_i(reg_d_i),
    .reg_e_i(reg_e_i), .reg_h_i(reg_h_i), .reg_l_i(reg_l_i),
    .hl_data_i(hl_data_i), .hl_valid_i(hl_valid_i), .imm_i(imm_i),
    .acc_o(acc_o), .flag_z_o(flag_z_o), .flag_n_o(flag_n_o),
    .flag_h_o(flag_h_o), .flag_c_o(flag_c_o),
    .pc_step_o(pc_step_o), .hl_rd_req_o(hl_rd_req_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [7:0] a,
                           input logic z, input logic n, input logic h, input logic c);
    chk(req, {acc_o, flag_z_o, flag_n_o, flag_h_o, flag_c_o}, {a, z, n, h, c});
  endtask

  // expected result from requirements R4..R8
  task automatic model(input int g, input int o);
    int a, ci, r, zsrc;
    a  = m_a;
    ci = (g == 1 || g == 3) ? int'(m_c) : 0;
    r  = a; zsrc = 0;
    m_n = 0; m_h = 0; m_c = 0;
    case (g)
      0, 1: begin
        r = a + o + ci;
        m_h = ((a % 16) + (o % 16) + ci) >= 16;
        m_c = r >= 256;
        r = r % 256; zsrc = r;
      end
      2, 3, 7: begin
        m_n = 1;
        m_h = (a % 16) < ((o % 16) + ci);
        m_c = a < (o + ci);
        zsrc = (a - o - ci + 512) % 256;
        r = (g == 7) ? a : zsrc;
      end
      4: begin r = a & o; m_h = 1; zsrc = r; end
      5: begin r = a ^ o; zsrc = r; end
      default: begin r = a | o; zsrc = r; end
    endcase
    m_z = (zsrc == 0);
    m_a = r[7:0];
  endtask

  function automatic int exp_step(input logic [7:0] opc);
    if (opc[7:6] == 2'b10) return 1;
    if (opc[7:6] == 2'b11 && opc[2:0] == 3'b110) return 2;
    return 0;
  endfunction

  // run one opcode to completion; checks comb outputs, then registered ones
  task automatic run_op(input logic [7:0] opc, input logic [7:0] imm,
                        input logic [7:0] hl, input string req);
    int o, s;
    @(negedge clk);
    opcode_i = opc; imm_i = imm; hl_data_i = hl; hl_valid_i = 1'b1; exec_i = 1'b1;
    #1;
    chk({req, " R3 pc_step"}, pc_step_o, exp_step(opc));
    chk({req, " R9 hl_req"}, hl_rd_req_o,
        (opc[7:6] == 2'b10 && opc[2:0] == 3'd6) ? 1 : 0);
    s = opc[2:0];
    if (exp_step(opc) == 2) o = imm;
    else case (s)
      0: o = reg_b_i; 1: o = reg_c_i; 2: o = reg_d_i; 3: o = reg_e_i;
      4: o = reg_h_i; 5: o = reg_l_i; 6: o = hl; default: o = m_a;
    endcase
    if (exp_step(opc) != 0) model(opc[5:3], o);
    @(negedge clk);
    exec_i = 1'b0; hl_valid_i = 1'b0;
    chk_state({req, " R2 state"}, m_a, m_z, m_n, m_h, m_c);
  endtask

  task automatic load_a(input logic [7:0] v);
    run_op(8'hE6, 8'h00, 8'h00, "R4 load clr");
    run_op(8'hF6, v, 8'h00, "R5 load set");
  endtask

  task automatic t_reset;
    chk_state("R1 reset", 8'h00, 0, 0, 0, 0);
    m_a = 0; m_z = 0; m_n = 0; m_h = 0; m_c = 0;
  endtask

  task automatic t_sweep;
    for (int g = 0; g < 8; g++) begin
      load_a(8'h9E - 8'(g * 11));
      for (int s = 0; s < 9; s++) begin
        logic [7:0] opc;
        opc = (s < 8) ? (8'h80 | 8'(g << 3) | 8'(s)) : (8'hC6 | 8'(g << 3));
        run_op(opc, 8'h5A + 8'(g * 37 + s), 8'hC3 ^ 8'(s * 29), "R2 sweep");
      end
    end
  endtask

  task automatic t_corners;
    load_a(8'h0F);
    run_op(8'hC6, 8'h01, 8'h00, "R6 add");
    chk_state("R6 add half", 8'h10, 0, 0, 1, 0);
    load_a(8'hFF);
    run_op(8'hC6, 8'h01, 8'h00, "R6 add");
    chk_state("R6 add wrap", 8'h00, 1, 0, 1, 1);
    run_op(8'hCE, 8'h0F, 8'h00, "R6 adc");
    chk_state("R6 adc cin", 8'h10, 0, 0, 1, 0);
    load_a(8'h10);
    run_op(8'hD6, 8'h01, 8'h00, "R7 sub");
    chk_state("R7 sub nibble", 8'h0F, 0, 1, 1, 0);
    load_a(8'hFF);
    run_op(8'hC6, 8'h01, 8'h00, "R7 prep");
    run_op(8'hDE, 8'hFF, 8'h00, "R7 sbc");
    chk_state("R7 sbc full borrow", 8'h00, 1, 1, 1, 1);
    load_a(8'h42);
    run_op(8'hFE, 8'h42, 8'h00, "R8 cp");
    chk_state("R8 cp equal", 8'h42, 1, 1, 0, 0);
    run_op(8'hBF, 8'h00, 8'h00, "R8 cp a");
    chk_state("R8 cp self", 8'h42, 1, 1, 0, 0);
    run_op(8'hA8 | 8'd7, 8'h00, 8'h00, "R5 xor");
    chk_state("R5 xor self", 8'h00, 1, 0, 0, 0);
    run_op(8'hA0, 8'h00, 8'h00, "R4 and");
    chk_state("R4 and zero", 8'h00, 1, 0, 1, 0);
  endtask

  task automatic t_mem_wait;
    load_a(8'h33);
    @(negedge clk);
    opcode_i = 8'hB6; hl_data_i = 8'h0C; hl_valid_i = 1'b0; exec_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R9 req while waiting", hl_rd_req_o, 1);
      @(negedge clk);
      chk_state("R9 hold while invalid", 8'h33, 0, 0, 0, 0);
    end
    hl_valid_i = 1'b1;
    @(negedge clk);
    exec_i = 1'b0; hl_valid_i = 1'b0;
    #1;
    chk("R9 req drops", hl_rd_req_o, 0);
    chk_state("R9 commit on valid", 8'h3F, 0, 0, 0, 0);
    m_a = 8'h3F; m_z = 0; m_n = 0; m_h = 0; m_c = 0;
  endtask

  task automatic t_idle;
    @(negedge clk);
    exec_i = 1'b0; opcode_i = 8'h90; imm_i = 8'hFF; hl_valid_i = 1'b1;
    reg_b_i = 8'h3F;
    repeat (4) @(negedge clk);
    chk_state("R10 idle hold", m_a, m_z, m_n, m_h, m_c);
    reg_b_i = 8'h3C;
    hl_valid_i = 1'b0;
  endtask

  task automatic t_unsupported;
    run_op(8'h00, 8'h12, 8'h00, "R3 unsup 00");
    chk_state("R3 unsup no change", m_a, m_z, m_n, m_h, m_c);
    run_op(8'h3C, 8'h12, 8'h00, "R3 unsup 3C");
    run_op(8'hC7, 8'h12, 8'h00, "R3 unsup C7");
  endtask

  initial begin
    rst_n = 1'b0; exec_i = 1'b0; opcode_i = 8'h00; imm_i = 8'h00;
    hl_data_i = 8'h00; hl_valid_i = 1'b0;
    reg_b_i = 8'h3C; reg_c_i = 8'h0F; reg_d_i = 8'hF0;
    reg_e_i = 8'h01; reg_h_i = 8'h80; reg_l_i = 8'hFF;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 sync release", 8'h00, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_sweep;
    t_corners;
    t_mem_wait;
    t_idle;
    t_unsupported;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule